// File: doc/BRIEF.md
# Macro and Micro Program Counter

This block keeps the program-counter state for a core that breaks each instruction into a run of micro-ops. It holds two pairs of registers. The macro pair is the address of the current instruction and the address of the following one. The micro pair is the index of the current micro-op and the index of the following one.

A sequencer drives it with three commands: load, micro-step and end-of-instruction. Load re-seeds everything from a given address. Micro-step walks through the micro-ops of one instruction. End-of-instruction retires the instruction and moves on to the next address. Two direct-write ports replace the next address or the next micro-index, so that a redirect (a taken branch or a microcode jump) can be recorded. The block then flags that the next values are no longer the plain sequential successors of the current ones.

The instruction size, the address width and the micro-index width are parameters. All address and index arithmetic wraps at the register width.

Top module: `mpc_state`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four registers (current address, next address, current micro-index, next micro-index) are cleared to zero.
- R2: A load moves the load address into the current address and the load address plus `INST_BYTES` into the next address. It also sets the current micro-index to 0 and the next micro-index to 1, all at the next clock edge.
- R3: A micro-step, with no load and no end-of-instruction, copies the next micro-index into the current micro-index and sets the next micro-index to its old value plus one. Both addresses are left unchanged.
- R4: An end-of-instruction, with no load, copies the next address into the current address and sets the next address to its old value plus `INST_BYTES`. It also returns the micro-indices to 0 (current) and 1 (next).
- R5: When commands coincide, load wins over end-of-instruction, and end-of-instruction wins over micro-step.
- R6: A direct write of the next address replaces the next address with the written value at the next edge and leaves the current address as the command alone would set it. It is applied on top of the result of any command in the same cycle.
- R7: A direct write of the next micro-index replaces the next micro-index at the next edge and leaves the current micro-index as the command alone would set it. It is applied on top of any command in the same cycle.
- R8: `branching_o` is high, combinationally from the registered values, exactly when the next address differs from the current address plus `INST_BYTES`, or when the next micro-index differs from the current micro-index plus one.
- R9: `micro_pc_o` always equals the current micro-index.
- R10: Address sums wrap modulo 2^`ADDR_W` and micro-index sums wrap modulo 2^`UIDX_W`. With the defaults, a load of 0xFFFFFFFC gives a next address of 0, and a micro-step from next index 255 gives a next index of 0.
- R11: In a cycle with no command and no direct write, all four registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load_i | input | 1 | Reinitialize from `load_addr_i` |
| load_addr_i | input | ADDR_W | Address for a load |
| step_i | input | 1 | Advance to the next micro-op |
| end_i | input | 1 | End the current instruction |
| npc_wr_i | input | 1 | Direct write of the next address |
| npc_wdata_i | input | ADDR_W | Value for the next address |
| nupc_wr_i | input | 1 | Direct write of the next micro-index |
| nupc_wdata_i | input | UIDX_W | Value for the next micro-index |
| pc_o | output | ADDR_W | Current instruction address |
| npc_o | output | ADDR_W | Next instruction address |
| upc_o | output | UIDX_W | Current micro-index |
| nupc_o | output | UIDX_W | Next micro-index |
| micro_pc_o | output | UIDX_W | Exported micro-PC |
| branching_o | output | 1 | Next values are not the sequential successors |

## Verification
The hardest situations to reach are cycles where a direct write coincides with a command. In those cycles the written value must land on top of the command's result, not be lost to it. The wrap of both counters is also hard to reach, because a micro-index needs hundreds of steps to hit its top naturally.

The stimulus aims at these cases directly. It writes a next micro-index of 255 and then steps, and it loads an address one instruction below the top of the address space. It also places writes in the same cycle as loads, steps and ends. A long random phase then mixes all inputs with a bias toward overlapping commands.

// File: rtl/mpc_pkg.sv
// Shared types for the macro/micro program counter.
// Assumes: command inputs are decoded to one action per cycle.
package mpc_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_END  = 2'd2,
        ACT_LOAD = 2'd3
    } mpc_act_e;

    // Pick the single winning action: load, then end, then step.
    function automatic mpc_act_e pick_action(input logic ld, input logic en, input logic st);
        if (ld)      return ACT_LOAD;
        else if (en) return ACT_END;
        else if (st) return ACT_STEP;
        else         return ACT_HOLD;
    endfunction

endpackage

// File: rtl/mpc_cmd_decode.sv
// Reduces the three command strobes to one prioritized action.
// Assumes: strobes may overlap freely; priority resolves them.
module mpc_cmd_decode
    import mpc_pkg::*;
(
    input  logic     load_i,
    input  logic     end_i,
    input  logic     step_i,
    output mpc_act_e act_o
);

    // Priority selection of the action for this cycle.
    always_comb begin
        act_o = pick_action(load_i, end_i, step_i);
    end

endmodule

// File: rtl/mpc_addr_pair.sv
// Holds the current and next instruction address.
// Assumes: INST_BYTES is the fixed instruction size; sums wrap at ADDR_W.
module mpc_addr_pair
    import mpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mpc_act_e          act_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              npc_wr_i,
    input  logic [ADDR_W-1:0] npc_wdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(INST_BYTES);

    logic [ADDR_W-1:0] pc_q, npc_q;
    logic [ADDR_W-1:0] pc_d, npc_d;

    // Next-state of the address pair: action first, then redirect write.
    always_comb begin
        pc_d  = pc_q;
        npc_d = npc_q;
        case (act_i)
            ACT_LOAD: begin
                pc_d  = load_addr_i;
                npc_d = load_addr_i + STRIDE;
            end
            ACT_END: begin
                pc_d  = npc_q;
                npc_d = npc_q + STRIDE;
            end
            default: ;
        endcase
        if (npc_wr_i) begin
            npc_d = npc_wdata_i;
        end
    end

    // Address registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            npc_q <= '0;
        end else begin
            pc_q  <= pc_d;
            npc_q <= npc_d;
        end
    end

    assign pc_o  = pc_q;
    assign npc_o = npc_q;

endmodule

// File: rtl/mpc_uidx_pair.sv
// Holds the current and next micro-op index.
// Assumes: index arithmetic wraps at UIDX_W.
module mpc_uidx_pair
    import mpc_pkg::*;
#(
    parameter int UIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mpc_act_e          act_i,
    input  logic              nupc_wr_i,
    input  logic [UIDX_W-1:0] nupc_wdata_i,
    output logic [UIDX_W-1:0] upc_o,
    output logic [UIDX_W-1:0] nupc_o
);

    localparam logic [UIDX_W-1:0] ONE = UIDX_W'(1);

    logic [UIDX_W-1:0] upc_q, nupc_q;
    logic [UIDX_W-1:0] upc_d, nupc_d;

    // Next-state of the index pair: action first, then redirect write.
    always_comb begin
        upc_d  = upc_q;
        nupc_d = nupc_q;
        case (act_i)
            ACT_LOAD, ACT_END: begin
                upc_d  = '0;
                nupc_d = ONE;
            end
            ACT_STEP: begin
                upc_d  = nupc_q;
                nupc_d = nupc_q + ONE;
            end
            default: ;
        endcase
        if (nupc_wr_i) begin
            nupc_d = nupc_wdata_i;
        end
    end

    // Index registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upc_q  <= '0;
            nupc_q <= '0;
        end else begin
            upc_q  <= upc_d;
            nupc_q <= nupc_d;
        end
    end

    assign upc_o  = upc_q;
    assign nupc_o = nupc_q;

endmodule

// File: rtl/mpc_seq_detect.sv
// Flags that the next address or next index is not the sequential successor.
// Assumes: inputs come straight from registers; output is combinational.
module mpc_seq_detect #(
    parameter int ADDR_W     = 32,
    parameter int UIDX_W     = 8,
    parameter int INST_BYTES = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] npc_i,
    input  logic [UIDX_W-1:0] upc_i,
    input  logic [UIDX_W-1:0] nupc_i,
    output logic              redirect_o
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(INST_BYTES);
    localparam logic [UIDX_W-1:0] ONE    = UIDX_W'(1);

    logic [ADDR_W-1:0] addr_succ;
    logic [UIDX_W-1:0] uidx_succ;

    // Sequential successors and their comparison.
    always_comb begin
        addr_succ  = pc_i + STRIDE;
        uidx_succ  = upc_i + ONE;
        redirect_o = (npc_i != addr_succ) || (nupc_i != uidx_succ);
    end

endmodule

// File: rtl/mpc_state.sv
// Top: macro and micro program counter state.
// Assumes: one action per cycle after priority; direct writes override the
// next values that the action produces.
module mpc_state
    import mpc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int UIDX_W     = 8,
    parameter int INST_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              step_i,
    input  logic              end_i,
    input  logic              npc_wr_i,
    input  logic [ADDR_W-1:0] npc_wdata_i,
    input  logic              nupc_wr_i,
    input  logic [UIDX_W-1:0] nupc_wdata_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] npc_o,
    output logic [UIDX_W-1:0] upc_o,
    output logic [UIDX_W-1:0] nupc_o,
    output logic [UIDX_W-1:0] micro_pc_o,
    output logic              branching_o
);

    mpc_act_e act;

    mpc_cmd_decode u_dec (
        .load_i (load_i),
        .end_i  (end_i),
        .step_i (step_i),
        .act_o  (act)
    );

    mpc_addr_pair #(
        .ADDR_W     (ADDR_W),
        .INST_BYTES (INST_BYTES)
    ) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .act_i       (act),
        .load_addr_i (load_addr_i),
        .npc_wr_i    (npc_wr_i),
        .npc_wdata_i (npc_wdata_i),
        .pc_o        (pc_o),
        .npc_o       (npc_o)
    );

    mpc_uidx_pair #(
        .UIDX_W (UIDX_W)
    ) u_uidx (
        .clk          (clk),
        .rst_n        (rst_n),
        .act_i        (act),
        .nupc_wr_i    (nupc_wr_i),
        .nupc_wdata_i (nupc_wdata_i),
        .upc_o        (upc_o),
        .nupc_o       (nupc_o)
    );

    mpc_seq_detect #(
        .ADDR_W     (ADDR_W),
        .UIDX_W     (UIDX_W),
        .INST_BYTES (INST_BYTES)
    ) u_seq (
        .pc_i       (pc_o),
        .npc_i      (npc_o),
        .upc_i      (upc_o),
        .nupc_i     (nupc_o),
        .redirect_o (branching_o)
    );

    // The exported micro-PC is the current micro-index.
    assign micro_pc_o = upc_o;

endmodule

// File: rtl/mpc_state_chk.sv
// Checker for mpc_state, attached by bind; observes ports only.
module mpc_state_chk #(
    parameter int ADDR_W     = 32,
    parameter int UIDX_W     = 8,
    parameter int INST_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [ADDR_W-1:0] load_addr_i,
    input logic              step_i,
    input logic              end_i,
    input logic              npc_wr_i,
    input logic [ADDR_W-1:0] npc_wdata_i,
    input logic              nupc_wr_i,
    input logic [UIDX_W-1:0] nupc_wdata_i,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] npc_o,
    input logic [UIDX_W-1:0] upc_o,
    input logic [UIDX_W-1:0] nupc_o,
    input logic              branching_o
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(INST_BYTES);
    localparam logic [UIDX_W-1:0] ONE    = UIDX_W'(1);

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && npc_o == '0 && upc_o == '0 && nupc_o == '0));

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !npc_wr_i && !nupc_wr_i) |=>
        (pc_o == $past(load_addr_i) && npc_o == $past(load_addr_i) + STRIDE
         && upc_o == '0 && nupc_o == ONE));

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !end_i && !npc_wr_i && !nupc_wr_i) |=>
        (upc_o == $past(nupc_o) && nupc_o == $past(nupc_o) + ONE
         && $stable(pc_o) && $stable(npc_o)));

    a_r4_end: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && !load_i && !npc_wr_i) |=>
        (pc_o == $past(npc_o) && npc_o == $past(npc_o) + STRIDE && upc_o == '0));

    a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (end_i || step_i)) |=> (pc_o == $past(load_addr_i) && upc_o == '0));

    a_r6_npc_write: assert property (@(posedge clk) disable iff (!rst_n)
        npc_wr_i |=> npc_o == $past(npc_wdata_i));

    a_r7_nupc_write: assert property (@(posedge clk) disable iff (!rst_n)
        nupc_wr_i |=> nupc_o == $past(nupc_wdata_i));

    a_r8_seq_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        ((load_i || end_i) && !npc_wr_i && !nupc_wr_i) |=> !branching_o);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !end_i && !step_i && !npc_wr_i && !nupc_wr_i) |=>
        ($stable(pc_o) && $stable(npc_o) && $stable(upc_o) && $stable(nupc_o)));

endmodule

bind mpc_state mpc_state_chk #(
    .ADDR_W     (ADDR_W),
    .UIDX_W     (UIDX_W),
    .INST_BYTES (INST_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load_i),
    .load_addr_i  (load_addr_i),
    .step_i       (step_i),
    .end_i        (end_i),
    .npc_wr_i     (npc_wr_i),
    .npc_wdata_i  (npc_wdata_i),
    .nupc_wr_i    (nupc_wr_i),
    .nupc_wdata_i (nupc_wdata_i),
    .pc_o         (pc_o),
    .npc_o        (npc_o),
    .upc_o        (upc_o),
    .nupc_o       (nupc_o),
    .branching_o  (branching_o)
);

// File: tb/mpc_state_tb.sv
// Bench for mpc_state: directed corners, then seeded random traffic,
// all compared against a reference model kept in the bench.
module mpc_state_tb;

    localparam int AW = 32;
    localparam int UW = 8;
    localparam int IB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic [AW-1:0] load_addr_i = '0;
    logic          step_i = 1'b0;
    logic          end_i = 1'b0;
    logic          npc_wr_i = 1'b0;
    logic [AW-1:0] npc_wdata_i = '0;
    logic          nupc_wr_i = 1'b0;
    logic [UW-1:0] nupc_wdata_i = '0;
    logic [AW-1:0] pc_o, npc_o;
    logic [UW-1:0] upc_o, nupc_o, micro_pc_o;
    logic          branching_o;

    always #10 clk = ~clk;

    mpc_state #(.ADDR_W(AW), .UIDX_W(UW), .INST_BYTES(IB)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
        .step_i(step_i), .end_i(end_i), .npc_wr_i(npc_wr_i),
        .npc_wdata_i(npc_wdata_i), .nupc_wr_i(nupc_wr_i),
        .nupc_wdata_i(nupc_wdata_i), .pc_o(pc_o), .npc_o(npc_o),
        .upc_o(upc_o), .nupc_o(nupc_o), .micro_pc_o(micro_pc_o),
        .branching_o(branching_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [AW-1:0] m_pc, m_npc;
    logic [UW-1:0] m_upc, m_nupc;

    // Branching per R8, from the model values.
    function automatic logic exp_branch(input logic [AW-1:0] p, input logic [AW-1:0] np,
                                        input logic [UW-1:0] u, input logic [UW-1:0] nu);
        logic [AW-1:0] asum;
        logic [UW-1:0] usum;
        asum = p + AW'(IB);
        usum = u + UW'(1);
        return (np != asum) || (nu != usum);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "pc", 64'(pc_o), 64'(m_pc));
        check(tag, "npc", 64'(npc_o), 64'(m_npc));
        check(tag, "upc", 64'(upc_o), 64'(m_upc));
        check(tag, "nupc", 64'(nupc_o), 64'(m_nupc));
        check("R9", "micro_pc", 64'(micro_pc_o), 64'(m_upc));
        check("R8", "branching", 64'(branching_o), 64'(exp_branch(m_pc, m_npc, m_upc, m_nupc)));
    endtask

    // One cycle: drive at negedge, advance model, compare at next negedge.
    task automatic cyc(input bit ld, input logic [AW-1:0] la, input bit st, input bit en,
                       input bit nw, input logic [AW-1:0] nd,
                       input bit uw, input logic [UW-1:0] ud, input string tag);
        load_i = ld; load_addr_i = la; step_i = st; end_i = en;
        npc_wr_i = nw; npc_wdata_i = nd; nupc_wr_i = uw; nupc_wdata_i = ud;
        if (ld) begin
            m_pc = la; m_npc = la + AW'(IB); m_upc = '0; m_nupc = UW'(1);
        end else if (en) begin
            m_pc = m_npc; m_npc = m_npc + AW'(IB); m_upc = '0; m_nupc = UW'(1);
        end else if (st) begin
            m_upc = m_nupc; m_nupc = m_nupc + UW'(1);
        end
        if (nw) m_npc = nd;
        if (uw) m_nupc = ud;
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        m_pc = '0; m_npc = '0; m_upc = '0; m_nupc = '0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        cyc(1, 32'h1000, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");
        cyc(0, 0, 1, 0, 0, 0, 1, 8'd7, "R7");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 0, 1, 32'h2000, 0, 0, "R6");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, "R4");
        cyc(0, 0, 0, 1, 1, 32'h3000, 0, 0, "R6");
        cyc(1, 32'h40, 1, 1, 0, 0, 0, 0, "R5");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R3");
        cyc(0, 0, 1, 1, 0, 0, 0, 0, "R5");
        cyc(1, 32'h500, 0, 0, 1, 32'h900, 1, 8'd4, "R6");
        cyc(1, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 1, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 1, 8'hFF, "R7");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 1, 0, 0, 0, 0, 0, "R10");
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R11");

        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[3:0] == 0, $urandom, r[5:4] != 0, r[8:6] == 0,
                r[11:9] == 0, $urandom, r[14:12] == 0, UW'($urandom), "R5");
        end

        rst_n = 1'b0;
        load_i = 0; step_i = 0; end_i = 0; npc_wr_i = 0; nupc_wr_i = 0;
        m_pc = '0; m_npc = '0; m_upc = '0; m_nupc = '0;
        @(negedge clk);
        check_all("R1");
        finish_run();
    end

endmodule